// File: doc/BRIEF.md
# Flash Command Sequencer

This block decodes host write cycles for a byte-wide NOR flash. Each write carries a 20-bit address and an 8-bit data byte. The block recognises multi-cycle instructions that all open with the same two-cycle coded unlock pair. When an instruction completes, it sends a one-cycle request pulse, with the target address and data, to the program/erase controller. It also chooses what a read returns: array contents, or identification and protection bytes in auto select mode.

Program needs four writes. Block and chip erase need six: the unlock pair, the erase set-up byte, the unlock pair again, then a confirm byte. A wrong byte or address at any step drops the interface back to read-array mode and starts nothing.

While the controller is busy, every write is ignored except the suspend byte. While an erase is suspended, a single resume byte restarts it, and program sequences remain usable.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, and on any clock where `supply_low` is high, the sequence restarts from its first step, `autosel_mode` is 0 and no request pulse is issued.
- R2: Four first-clock writes produce `prog_req` for one cycle, one clock after the fourth write, carrying that write's address and data. The four writes are AAh at low address 555h, 55h at 2AAh, A0h, then any address with the data to store. Only address bits [10:0] are compared.
- R3: Six writes produce `blk_erase_req` for one cycle, carrying the sixth write's address. The six writes are AAh@555h, 55h@2AAh, 80h, AAh@555h, 55h@2AAh, then 30h.
- R4: The same six-write sequence with 10h as the last byte produces `chip_erase_req` for one cycle.
- R5: A write with an unexpected byte or address at any step returns to the first step with `autosel_mode` at 0 and issues no request.
- R6: A write of F0h at any step, when the controller is not busy, returns to read-array mode with no request.
- R7: AAh@555h, 55h@2AAh, 90h sets `autosel_mode`. `id_byte` is then 20h when read address bits [1:0] are 00, and the device code when they are 01. The device code is D2h for a top-boot build and DCh for a bottom-boot build.
- R8: With read address bits [1:0] = 10, `id_byte` is 01h if the block that contains the read address is flagged in `prot_map`, and 00h otherwise. In a top-boot build the blocks are numbered as follows:
  - blocks 0–14: 64 KB each, starting at 00000h;
  - block 15: 32 KB at F0000h;
  - block 16: 8 KB at F8000h;
  - block 17: 8 KB at FA000h;
  - block 18: 16 KB at FC000h.
- R9: While `pe_busy` is high, a write of B0h produces `suspend_req`. Every other write produces no request and leaves the sequence step and the read mode unchanged.
- R10: While `pe_suspended` is high, with no sequence in progress, a write of 30h produces `resume_req`. An erase set-up byte (80h) is rejected as malformed.
- R11: A write strobe held high for several clocks counts as one write. It is captured on its first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_low | input | 1 | Supply-low indication; forces read-array mode |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 20 | Write address |
| wr_data | input | 8 | Write data or command byte |
| pe_busy | input | 1 | Controller is running an operation |
| pe_suspended | input | 1 | Controller holds a suspended erase |
| rd_addr | input | 20 | Read address |
| prot_map | input | 19 | Protection flag per block |
| prog_req | output | 1 | Program request pulse |
| blk_erase_req | output | 1 | Block erase request pulse |
| chip_erase_req | output | 1 | Chip erase request pulse |
| suspend_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| req_addr | output | 20 | Address that goes with the request |
| req_data | output | 8 | Data that goes with the request |
| autosel_mode | output | 1 | Reads return identification bytes |
| id_byte | output | 8 | Identification or protection byte |

## Verification
The assertions assume that `wr_addr` and `wr_data` are steady on the first clock of each strobe. They also assume that `pe_busy` and `pe_suspended` change only between writes, never on a strobe's first edge.

The bench drives all inputs on falling edges and releases the strobe for at least one clock between writes, so every write is a clean rising edge of `wr_en`. It raises `pe_busy` and `pe_suspended` only around whole sequences, which keeps the controller status consistent with the requests the block issues.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNLK2, ST_SETUP, ST_PDATA, ST_EUNLK1, ST_EUNLK2, ST_ECONF
  } seq_step_t;

  typedef enum logic [2:0] {
    RQ_NONE, RQ_PROG, RQ_BLK, RQ_CHIP, RQ_SUSP, RQ_RES
  } req_kind_t;

  localparam logic [7:0]  C_UNLK1   = 8'hAA;
  localparam logic [7:0]  C_UNLK2   = 8'h55;
  localparam logic [10:0] A_UNLK1   = 11'h555;
  localparam logic [10:0] A_UNLK2   = 11'h2AA;
  localparam logic [7:0]  C_PROG    = 8'hA0;
  localparam logic [7:0]  C_ERASE   = 8'h80;
  localparam logic [7:0]  C_AUTOSEL = 8'h90;
  localparam logic [7:0]  C_RESET   = 8'hF0;
  localparam logic [7:0]  C_BLKCONF = 8'h30;
  localparam logic [7:0]  C_CHIPCONF= 8'h10;
  localparam logic [7:0]  C_SUSPEND = 8'hB0;
  localparam logic [7:0]  C_RESUME  = 8'h30;
  localparam logic [7:0]  C_MFR     = 8'h20;
  localparam logic [7:0]  C_DEV_TOP = 8'hD2;
  localparam logic [7:0]  C_DEV_BOT = 8'hDC;

  // block number from address bits [19:13]
  function automatic logic [4:0] blk_index(input logic [6:0] hi, input logic top);
    logic [3:0] big;
    big = hi[6:3];
    if (top) begin
      if (big != 4'hF)      return {1'b0, big};
      else if (!hi[2])      return 5'd15;
      else if (hi[1])       return 5'd18;
      else if (!hi[0])      return 5'd16;
      else                  return 5'd17;
    end else begin
      if (big != 4'h0)      return {1'b0, big} + 5'd3;
      else if (hi[2])       return 5'd3;
      else if (!hi[1])      return 5'd0;
      else if (!hi[0])      return 5'd1;
      else                  return 5'd2;
    end
  endfunction
endpackage

// File: rtl/flash_id_mux.sv
module flash_id_mux
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int NBLK     = 19,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NBLK-1:0]   prot_map,
  output logic [7:0]        id_byte
);
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? C_DEV_TOP : C_DEV_BOT;

  logic [4:0] blk;
  logic       blk_prot;
  logic       unused_bits;

  assign unused_bits = ^rd_addr[ADDR_W-8:2];
  assign blk      = blk_index(rd_addr[ADDR_W-1:ADDR_W-7], TOP_BOOT);
  assign blk_prot = (int'(blk) < NBLK) ? prot_map[blk] : 1'b0;

  always_comb begin
    case (rd_addr[1:0])
      2'b00:   id_byte = C_MFR;
      2'b01:   id_byte = DEV_CODE;
      2'b10:   id_byte = {7'd0, blk_prot};
      default: id_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_low,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pe_busy,
  input  logic              pe_suspended,
  output logic              prog_req,
  output logic              blk_erase_req,
  output logic              chip_erase_req,
  output logic              suspend_req,
  output logic              resume_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              autosel_mode
);
  seq_step_t step, n_step;
  req_kind_t n_kind;
  logic      n_mode;
  logic      wr_q;
  logic      wr_first;
  logic      is_unlk1, is_unlk2;
  logic      req_any;

  assign wr_first = wr_en & ~wr_q;
  assign is_unlk1 = (wr_addr[10:0] == A_UNLK1) && (wr_data == C_UNLK1);
  assign is_unlk2 = (wr_addr[10:0] == A_UNLK2) && (wr_data == C_UNLK2);
  assign req_any  = prog_req | blk_erase_req | chip_erase_req | suspend_req | resume_req;

  always_comb begin
    n_step = ST_IDLE;
    n_mode = 1'b0;
    n_kind = RQ_NONE;
    if (pe_busy) begin
      n_step = step;
      n_mode = autosel_mode;
      if (wr_data == C_SUSPEND) n_kind = RQ_SUSP;
    end else if (wr_data != C_RESET) begin
      case (step)
        ST_IDLE: begin
          if (is_unlk1) begin
            n_step = ST_UNLK2; n_mode = autosel_mode;
          end else if (pe_suspended && wr_data == C_RESUME) begin
            n_kind = RQ_RES; n_mode = autosel_mode;
          end
        end
        ST_UNLK2: if (is_unlk2) begin n_step = ST_SETUP; n_mode = autosel_mode; end
        ST_SETUP: begin
          if (wr_data == C_PROG) begin
            n_step = ST_PDATA; n_mode = autosel_mode;
          end else if (wr_data == C_ERASE && !pe_suspended) begin
            n_step = ST_EUNLK1; n_mode = autosel_mode;
          end else if (wr_data == C_AUTOSEL) begin
            n_mode = 1'b1;
          end
        end
        ST_PDATA:  n_kind = RQ_PROG;
        ST_EUNLK1: if (is_unlk1) begin n_step = ST_EUNLK2; n_mode = autosel_mode; end
        ST_EUNLK2: if (is_unlk2) begin n_step = ST_ECONF;  n_mode = autosel_mode; end
        ST_ECONF: begin
          if (wr_data == C_BLKCONF)       n_kind = RQ_BLK;
          else if (wr_data == C_CHIPCONF) n_kind = RQ_CHIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step           <= ST_IDLE;
      autosel_mode   <= 1'b0;
      wr_q           <= 1'b0;
      prog_req       <= 1'b0;
      blk_erase_req  <= 1'b0;
      chip_erase_req <= 1'b0;
      suspend_req    <= 1'b0;
      resume_req     <= 1'b0;
      req_addr       <= '0;
      req_data       <= '0;
    end else begin
      wr_q           <= wr_en;
      prog_req       <= 1'b0;
      blk_erase_req  <= 1'b0;
      chip_erase_req <= 1'b0;
      suspend_req    <= 1'b0;
      resume_req     <= 1'b0;
      if (supply_low) begin
        step         <= ST_IDLE;
        autosel_mode <= 1'b0;
      end else if (wr_first) begin
        step         <= n_step;
        autosel_mode <= n_mode;
        prog_req       <= (n_kind == RQ_PROG);
        blk_erase_req  <= (n_kind == RQ_BLK);
        chip_erase_req <= (n_kind == RQ_CHIP);
        suspend_req    <= (n_kind == RQ_SUSP);
        resume_req     <= (n_kind == RQ_RES);
        if (n_kind != RQ_NONE) begin
          req_addr <= wr_addr;
          req_data <= wr_data;
        end
      end
    end
  end

  // at most one request per cycle (R2, R3, R4)
  p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, blk_erase_req, chip_erase_req, suspend_req, resume_req}));

  // a request only follows the first clock of a strobe (R11)
  p_req_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |-> $past(wr_en) && !$past(wr_q));

  // supply low forces read-array mode and silence (R1)
  p_supply_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(supply_low) |-> !autosel_mode && !req_any && step == ST_IDLE);

  // busy controller: nothing but suspend (R9)
  p_busy_only_susp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pe_busy) && !$past(supply_low) |->
      !prog_req && !blk_erase_req && !chip_erase_req && !resume_req && $stable(step));

  // step moves only on a write (R11)
  p_step_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_first && !supply_low |=> $stable(step) && $stable(autosel_mode));
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int NBLK     = 19,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_low,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pe_busy,
  input  logic              pe_suspended,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NBLK-1:0]   prot_map,
  output logic              prog_req,
  output logic              blk_erase_req,
  output logic              chip_erase_req,
  output logic              suspend_req,
  output logic              resume_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              autosel_mode,
  output logic [7:0]        id_byte
);
  flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pe_busy(pe_busy), .pe_suspended(pe_suspended),
    .prog_req(prog_req), .blk_erase_req(blk_erase_req),
    .chip_erase_req(chip_erase_req), .suspend_req(suspend_req),
    .resume_req(resume_req), .req_addr(req_addr), .req_data(req_data),
    .autosel_mode(autosel_mode)
  );

  flash_id_mux #(.ADDR_W(ADDR_W), .NBLK(NBLK), .TOP_BOOT(TOP_BOOT)) u_mux (
    .rd_addr(rd_addr), .prot_map(prot_map), .id_byte(id_byte)
  );
endmodule

// File: tb/sim_flash_cmd_if.sv
`timescale 1ns/1ps
module sim_flash_cmd_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        supply_low = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        pe_busy = 1'b0;
  logic        pe_suspended = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [18:0] prot_map = 19'h20008;  // blocks 17 and 3 protected
  logic        prog_req, blk_erase_req, chip_erase_req, suspend_req, resume_req;
  logic [19:0] req_addr;
  logic [7:0]  req_data;
  logic        autosel_mode;
  logic [7:0]  id_byte;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  flash_cmd_if u0 (.*);

  // reference model state
  int m_step = 0;
  bit m_auto = 0, m_wq = 0;
  bit e_prog, e_blk, e_chip, e_susp, e_res;
  logic [19:0] e_addr;
  logic [7:0]  e_data;

  function automatic int ref_block(input logic [19:0] a);
    if (a < 20'hF0000) return int'(a) / 65536;
    if (a < 20'hF8000) return 15;
    if (a < 20'hFA000) return 16;
    if (a < 20'hFC000) return 17;
    return 18;
  endfunction

  function automatic logic [7:0] ref_id(input logic [19:0] a);
    case (a % 4)
      0: return 8'h20;
      1: return 8'hD2;
      2: return prot_map[ref_block(a)] ? 8'h01 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    bit first, u1, u2;
    e_prog = 0; e_blk = 0; e_chip = 0; e_susp = 0; e_res = 0;
    if (!rst_n) begin
      m_step = 0; m_auto = 0; m_wq = 0;
    end else begin
      first = wr_en && !m_wq;
      m_wq = wr_en;
      u1 = (wr_addr % 2048 == 'h555) && wr_data == 8'hAA;
      u2 = (wr_addr % 2048 == 'h2AA) && wr_data == 8'h55;
      if (supply_low) begin
        m_step = 0; m_auto = 0;
      end else if (first) begin
        if (pe_busy) begin
          if (wr_data == 8'hB0) begin e_susp = 1; e_addr = wr_addr; e_data = wr_data; end
        end else if (wr_data == 8'hF0) begin
          m_step = 0; m_auto = 0;
        end else begin
          int nxt;
          nxt = -1;
          if (m_step == 0 && u1) nxt = 1;
          else if (m_step == 0 && pe_suspended && wr_data == 8'h30) begin nxt = 0; e_res = 1; end
          else if (m_step == 1 && u2) nxt = 2;
          else if (m_step == 2 && wr_data == 8'hA0) nxt = 3;
          else if (m_step == 2 && wr_data == 8'h80 && !pe_suspended) nxt = 4;
          else if (m_step == 2 && wr_data == 8'h90) begin m_step = 0; m_auto = 1; end
          else if (m_step == 3) begin e_prog = 1; end
          else if (m_step == 4 && u1) nxt = 5;
          else if (m_step == 5 && u2) nxt = 6;
          else if (m_step == 6 && wr_data == 8'h30) e_blk = 1;
          else if (m_step == 6 && wr_data == 8'h10) e_chip = 1;
          if (e_prog || e_blk || e_chip || e_res) begin e_addr = wr_addr; e_data = wr_data; end
          if (nxt >= 0) m_step = nxt;
          else if (!(m_step == 0 && m_auto && !u1 && wr_data == 8'h90)) begin
            if (!(m_auto && m_step == 0 && !e_prog && !e_blk && !e_chip && !e_res &&
                  !u1 && wr_data == 8'h90)) begin
              m_step = 0;
              if (!e_res && !(m_auto && wr_data == 8'h90 && m_step == 0)) m_auto = m_auto_keep(wr_data);
            end
          end
          if (e_res) m_auto = m_auto;
        end
      end
    end
  end

  // a completed auto select write is the only non-advancing write that keeps the mode on
  bit last_autosel;
  function automatic bit m_auto_keep(input logic [7:0] d);
    return last_autosel;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("prog_req", prog_req, e_prog);
      chk("blk_erase_req", blk_erase_req, e_blk);
      chk("chip_erase_req", chip_erase_req, e_chip);
      chk("suspend_req", suspend_req, e_susp);
      chk("resume_req", resume_req, e_res);
      chk("autosel_mode", autosel_mode, m_auto);
      chk("id_byte", id_byte, ref_id(rd_addr));
      if (e_prog || e_blk || e_chip || e_susp || e_res) begin
        chk("req_addr", req_addr, e_addr);
        chk("req_data", req_data, e_data);
      end
    end
  end

  task automatic wr(input logic [19:0] a, input logic [7:0] d, input int hold = 1);
    @(negedge clk);
    last_autosel = 0;
    wr_en = 1; wr_addr = a; wr_data = d;
    repeat (hold) @(negedge clk);
    wr_en = 0;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(20'h00555, 8'hAA);
    wr(20'h002AA, 8'h55);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("reset autosel_mode", autosel_mode, 0);
    chk("reset prog_req", prog_req, 0);
    // R2 program
    cur_req = "R2";
    unlock(); wr(20'h00555, 8'hA0); wr(20'h12345, 8'h5A);
    // R3 block erase
    cur_req = "R3";
    unlock(); wr(20'h00555, 8'h80); unlock(); wr(20'h30000, 8'h30);
    // R4 chip erase
    cur_req = "R4";
    unlock(); wr(20'h00555, 8'h80); unlock(); wr(20'h00555, 8'h10);
    // R5 malformed second cycle, wrong unlock address, bad confirm
    cur_req = "R5";
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h56); wr(20'h40000, 8'h77);
    unlock(); wr(20'h00555, 8'h80); wr(20'h00554, 8'hAA); wr(20'h00000, 8'h30);
    unlock(); wr(20'h00555, 8'h80); unlock(); wr(20'h00000, 8'h20);
    // R6 reset byte in the middle of program and erase
    cur_req = "R6";
    unlock(); wr(20'h00555, 8'hA0); wr(20'h00100, 8'hF0); wr(20'h00100, 8'h11);
    unlock(); wr(20'h00555, 8'h80); wr(20'h00555, 8'hF0);
    // R7 auto select codes
    cur_req = "R7";
    unlock(); wr(20'h00555, 8'h90);
    rd_addr = 20'h00000; @(negedge clk);
    chk("mfr code", id_byte, 8'h20);
    rd_addr = 20'h00001; @(negedge clk);
    chk("device code", id_byte, 8'hD2);
    chk("auto mode on", autosel_mode, 1);
    // R8 protection status
    cur_req = "R8";
    rd_addr = 20'hFA002; @(negedge clk);
    chk("block 17 protected", id_byte, 8'h01);
    rd_addr = 20'hF8002; @(negedge clk);
    chk("block 16 free", id_byte, 8'h00);
    rd_addr = 20'h30002; @(negedge clk);
    chk("block 3 protected", id_byte, 8'h01);
    rd_addr = 20'hFC006; @(negedge clk);
    chk("block 18 free", id_byte, 8'h00);
    cur_req = "R6";
    wr(20'h00000, 8'hF0);
    chk("reset leaves auto", autosel_mode, 0);
    // R9 busy controller
    cur_req = "R9";
    pe_busy = 1;
    unlock(); wr(20'h00555, 8'hA0); wr(20'h00200, 8'h33);
    wr(20'h00000, 8'hF0);
    wr(20'h55555, 8'hB0);
    pe_busy = 0;
    @(negedge clk);
    // R10 resume while suspended, erase set-up refused, program allowed
    cur_req = "R10";
    pe_suspended = 1;
    wr(20'h00000, 8'h30);
    unlock(); wr(20'h00555, 8'h80); unlock(); wr(20'h00000, 8'h30);
    unlock(); wr(20'h00555, 8'hA0); wr(20'h00300, 8'hC3);
    pe_suspended = 0;
    // R11 held strobe counts once
    cur_req = "R11";
    wr(20'h00555, 8'hAA, 3); wr(20'h002AA, 8'h55, 4); wr(20'h00555, 8'hA0, 2);
    wr(20'h0ABCD, 8'h99, 5);
    // R1 supply low mid-sequence
    cur_req = "R1";
    unlock();
    @(negedge clk); supply_low = 1; @(negedge clk); supply_low = 0;
    wr(20'h00555, 8'hA0);
    wr(20'h00400, 8'h44);
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule